// File: doc/BRIEF.md
# Dual-Output Latency-Insensitive Dataflow Node

This block wraps a two-input combinational function so that it can sit between bounded queues in a dataflow network. Operand `a` and operand `b` each arrive as the head of a queue. Result `c` is a function of both heads. Result `d` is a plain copy of the `b` head. Each result goes out to its own queue. The queues are outside the block. Each one presents a not-empty or not-full flag and a head value, and it accepts a one-cycle enqueue or dequeue strobe.

The two results are produced independently. Each result has its own done flag. A result fires once its own operands are present and its own output queue has room, so `d` never waits for `a`. Once both results of a step have been written, the block pops one entry from each input queue in a separate cycle and clears both flags. This removes the false dependency that would otherwise deadlock a loop in which `d` feeds back into `a`. It also makes the node pop every input once for every pair of outputs it produces.

The function is chosen at elaboration time from addition, exclusive-or and subtraction.

Top module: `li_dual_out_node`

## Requirements
- R1: `c_data` equals f(`a_first`, `b_first`) modulo 2^DATA_W. With the default FUNC (FN_ADD), f is `a_first + b_first`.
- R2: `d_data` always equals `b_first`, unchanged.
- R3: `c_enq` is high in a cycle exactly when the c done flag is clear, `a_not_empty` and `b_not_empty` are high, and `c_not_full` is high. While `c_not_full` is low, no c result is produced.
- R4: `d_enq` is high in a cycle exactly when the d done flag is clear, `b_not_empty` is high and `d_not_full` is high, whatever the state of `a_not_empty`.
- R5: Each result is enqueued at most once per step. After `c_enq` (or `d_enq`) has been high, it stays low until the step has finished.
- R6: The finish cycle is the cycle after the later of the two result cycles. In it, `a_deq` and `b_deq` are high together for exactly one cycle, and neither `c_enq` nor `d_enq` is high.
- R7: A synchronous active-low reset clears both done flags. Right after reset with inputs present, both results fire at once. With the inputs empty, no strobe is high.
- R8: The node is self-cleaning. In any run, the number of dequeues equals the number of completed steps, and it also equals the counts of `c` and `d` results.
- R9: Suppose `d` is looped back into `a` through a queue of depth 1 that holds an initial token, with a depth-1 queue on `d`. Then the loop never stalls. The c sequence is f(a_n, b_n), where a_0 is the token and a_n = b_{n-1}.
- R10: The `c` and `d` results can fire in the same cycle when all their conditions hold at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_not_empty | input | 1 | Queue a holds at least one entry |
| a_first | input | DATA_W | Head of queue a |
| a_deq | output | 1 | Pop queue a this cycle |
| b_not_empty | input | 1 | Queue b holds at least one entry |
| b_first | input | DATA_W | Head of queue b |
| b_deq | output | 1 | Pop queue b this cycle |
| c_not_full | input | 1 | Queue c can accept an entry |
| c_enq | output | 1 | Push `c_data` into queue c this cycle |
| c_data | output | DATA_W | Function result |
| d_not_full | input | 1 | Queue d can accept an entry |
| d_enq | output | 1 | Push `d_data` into queue d this cycle |
| d_data | output | DATA_W | Copy of the b head |

## Verification
The function is first driven with a table of operand pairs while the output queues are drained freely. This shows that results are computed correctly, including carry wrap, zero and sign-bit cases. The same table is then run with shallow output queues that are drained only every second or third cycle. This separates a node that lets each result wait only on its own queue from one that loses or duplicates results under backpressure. Directed cycles pull the conditions apart one at a time: a missing `a`, a full `c`, and all conditions ready at once. These cases show the independent firing, the once-per-step rule and the separate finish cycle. A feedback run from `d` to `a` with a single token shows that the node does not deadlock, and it checks the resulting shifted sequence.

// File: rtl/li_node_pkg.sv
// Package: shared types for the dual-output dataflow node.
// Assumes: nothing; pure type definitions.
package li_node_pkg;

    // Selects the combinational function applied to the two operands.
    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_XOR = 2'd1,
        FN_SUB = 2'd2
    } func_e;

endpackage

// File: rtl/li_node_func.sv
// Module: li_node_func
// Purely combinational operand function, variant picked at elaboration.
// Assumes: operands are stable heads of their queues; result wraps mod 2^DATA_W.
module li_node_func
    import li_node_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter func_e FUNC   = FN_ADD
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] result
);

    // Build exactly one datapath according to FUNC.
    generate
        if (FUNC == FN_ADD) begin : g_add
            assign result = lhs + rhs;
        end else if (FUNC == FN_XOR) begin : g_xor
            assign result = lhs ^ rhs;
        end else begin : g_sub
            assign result = lhs - rhs;
        end
    endgenerate

endmodule

// File: rtl/li_node_done_flag.sv
// Module: li_node_done_flag
// Fire control for one output: fires when its own conditions are ready and
// it has not yet fired in the current step, then holds a done flag until
// the step is closed by the finish signal.
// Assumes: clear is only raised while done is set.
module li_node_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic clear,
    output logic fire,
    output logic done
);

    // Output strobe: allowed once per step.
    assign fire = ready && !done;

    // Done flag: set on fire, cleared by finish or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (clear) begin
            done <= 1'b0;
        end else if (fire) begin
            done <= 1'b1;
        end
    end

    // R5: after firing, the strobe stays low the next cycle.
    a_r5_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R5: a set flag survives until the step is closed.
    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);

endmodule

// File: rtl/li_dual_out_node.sv
// Module: li_dual_out_node
// Dataflow wrapper for a two-input, two-output combinational step:
// c = f(a, b), d = b. Each output fires on its own conditions; both inputs
// are popped in a later cycle once both outputs have been produced.
// Assumes: queue heads stay put until popped; queues ignore nothing, so
// enq is only raised when not_full and deq only when not_empty.
module li_dual_out_node
    import li_node_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter func_e FUNC   = FN_ADD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_not_empty,
    input  logic [DATA_W-1:0] a_first,
    output logic              a_deq,
    input  logic              b_not_empty,
    input  logic [DATA_W-1:0] b_first,
    output logic              b_deq,
    input  logic              c_not_full,
    output logic              c_enq,
    output logic [DATA_W-1:0] c_data,
    input  logic              d_not_full,
    output logic              d_enq,
    output logic [DATA_W-1:0] d_data
);

    logic c_ready;
    logic d_ready;
    logic c_done;
    logic d_done;
    logic step_done;

    // Per-output readiness: each depends only on its own operands and sink.
    assign c_ready = a_not_empty && b_not_empty && c_not_full;
    assign d_ready = b_not_empty && d_not_full;

    // Finish: both results registered as produced in earlier cycles.
    assign step_done = c_done && d_done;

    // Fire control for the function output.
    li_node_done_flag u_c_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (c_ready),
        .clear (step_done),
        .fire  (c_enq),
        .done  (c_done)
    );

    // Fire control for the pass-through output.
    li_node_done_flag u_d_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (d_ready),
        .clear (step_done),
        .fire  (d_enq),
        .done  (d_done)
    );

    // Function datapath.
    li_node_func #(
        .DATA_W (DATA_W),
        .FUNC   (FUNC)
    ) u_func (
        .lhs    (a_first),
        .rhs    (b_first),
        .result (c_data)
    );

    // Pass-through output and paired pops.
    assign d_data = b_first;
    assign a_deq  = step_done;
    assign b_deq  = step_done;

    // R6: the finish pop lasts one cycle.
    a_r6_finish_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        a_deq |=> !a_deq);

    // R6: no result is written in the finish cycle.
    a_r6_quiet_finish: assert property (@(posedge clk) disable iff (!rst_n)
        a_deq |-> (!c_enq && !d_enq));

    // R8: pops only target queues that still hold the consumed heads.
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        b_deq |-> (a_not_empty && b_not_empty));

    // R3: no c result while its sink is full.
    a_r3_c_sink_room: assert property (@(posedge clk) disable iff (!rst_n)
        c_enq |-> c_not_full);

endmodule

// File: tb/li_dual_out_node_tb_top.sv
// Bench queue model: capacity chosen at run time (1..4), no bypass.
module li_tb_fifo #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   cap,
    input  logic         enq,
    input  logic [W-1:0] din,
    input  logic         deq,
    output logic         not_empty,
    output logic         not_full,
    output logic [W-1:0] first
);
    logic [W-1:0] mem [4];
    logic [1:0]   rd;
    logic [1:0]   wr;
    logic [2:0]   cnt;
    logic         do_enq;
    logic         do_deq;

    assign not_empty = (cnt != 3'd0);
    assign not_full  = (cnt < cap);
    assign first     = mem[rd];
    assign do_enq    = enq && not_full;
    assign do_deq    = deq && not_empty;

    // Queue storage and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd  <= 2'd0;
            wr  <= 2'd0;
            cnt <= 3'd0;
        end else begin
            if (do_enq) begin
                mem[wr] <= din;
                wr      <= wr + 2'd1;
            end
            if (do_deq) rd <= rd + 2'd1;
            cnt <= cnt + {2'd0, do_enq} - {2'd0, do_deq};
        end
    end
endmodule

module li_dual_out_node_tb_top;
    localparam int W = 8;
    localparam int N = 8;
    localparam logic [7:0] TOKEN = 8'h33;
    // Operand table: {a, b}.
    localparam logic [15:0] VEC [N] = '{
        16'h0102, 16'hFF01, 16'h0000, 16'h8080,
        16'h3CC3, 16'h7F01, 16'hAA55, 16'h10F0
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic fifo_mode, loop_mode;
    logic dr_a_ne, dr_b_ne, dr_c_nf, dr_d_nf;
    logic [W-1:0] dr_a_first, dr_b_first;
    logic push_a, push_b;
    logic [W-1:0] push_a_data, push_b_data;
    logic [2:0] cap_a, cap_b, cap_c, cap_d;
    int c_div, d_div, cyc;

    logic a_not_empty, b_not_empty, c_not_full, d_not_full;
    logic [W-1:0] a_first, b_first, c_data, d_data;
    logic a_deq, b_deq, c_enq, d_enq;

    logic fa_ne, fa_nf, fb_ne, fb_nf, fc_ne, fc_nf, fd_ne, fd_nf;
    logic [W-1:0] fa_first, fb_first, fc_first, fd_first;
    logic xfer, fa_enq, fd_deq, fc_deq;
    logic [W-1:0] fa_din;

    int checks = 0;
    int errors = 0;
    int c_cnt, d_cnt, deq_cnt;
    logic [W-1:0] c_log [N];
    logic [W-1:0] d_log [N];

    // Bench-side connections between the DUT and either direct drive or queues.
    always_comb begin
        a_not_empty = fifo_mode ? fa_ne : dr_a_ne;
        a_first     = fifo_mode ? fa_first : dr_a_first;
        b_not_empty = fifo_mode ? fb_ne : dr_b_ne;
        b_first     = fifo_mode ? fb_first : dr_b_first;
        c_not_full  = fifo_mode ? fc_nf : dr_c_nf;
        d_not_full  = fifo_mode ? fd_nf : dr_d_nf;
        xfer        = loop_mode && fd_ne && fa_nf && !push_a;
        fa_enq      = push_a || xfer;
        fa_din      = push_a ? push_a_data : fd_first;
        fd_deq      = loop_mode ? xfer : (fd_ne && (cyc % d_div == 0));
        fc_deq      = fc_ne && (cyc % c_div == 0);
    end

    li_tb_fifo #(.W(W)) u_fa (.clk(clk), .rst_n(rst_n), .cap(cap_a), .enq(fa_enq),
        .din(fa_din), .deq(fifo_mode && a_deq), .not_empty(fa_ne), .not_full(fa_nf), .first(fa_first));
    li_tb_fifo #(.W(W)) u_fb (.clk(clk), .rst_n(rst_n), .cap(cap_b), .enq(push_b),
        .din(push_b_data), .deq(fifo_mode && b_deq), .not_empty(fb_ne), .not_full(fb_nf), .first(fb_first));
    li_tb_fifo #(.W(W)) u_fc (.clk(clk), .rst_n(rst_n), .cap(cap_c), .enq(fifo_mode && c_enq),
        .din(c_data), .deq(fc_deq), .not_empty(fc_ne), .not_full(fc_nf), .first(fc_first));
    li_tb_fifo #(.W(W)) u_fd (.clk(clk), .rst_n(rst_n), .cap(cap_d), .enq(fifo_mode && d_enq),
        .din(d_data), .deq(fd_deq), .not_empty(fd_ne), .not_full(fd_nf), .first(fd_first));

    li_dual_out_node #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_not_empty(a_not_empty), .a_first(a_first), .a_deq(a_deq),
        .b_not_empty(b_not_empty), .b_first(b_first), .b_deq(b_deq),
        .c_not_full(c_not_full), .c_enq(c_enq), .c_data(c_data),
        .d_not_full(d_not_full), .d_enq(d_enq), .d_data(d_data)
    );

    // Cycle counter for drain patterns.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Port monitor: logs results and pops once per cycle, away from the edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            c_cnt = 0; d_cnt = 0; deq_cnt = 0;
        end else if (fifo_mode) begin
            if (c_enq) begin
                if (c_cnt < N) c_log[c_cnt] = c_data;
                c_cnt++;
            end
            if (d_enq) begin
                if (d_cnt < N) d_log[d_cnt] = d_data;
                d_cnt++;
            end
            if (a_deq && b_deq) deq_cnt++;
        end
    end

    function automatic logic [W-1:0] ref_f(input logic [W-1:0] x, input logic [W-1:0] y);
        return x + y;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_steps();
        for (int k = 0; k < 400 && deq_cnt < N; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Runs the operand table through the queues; loop selects feedback mode.
    task automatic run_table(input bit loop, input string tag);
        fifo_mode = 1'b1;
        loop_mode = loop;
        do_reset();
        if (loop) begin
            push_a = 1'b1; push_a_data = TOKEN;
            @(negedge clk);
            push_a = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            while (!fb_nf || (!loop && !fa_nf)) @(negedge clk);
            push_b = 1'b1; push_b_data = VEC[i][7:0];
            push_a = !loop; push_a_data = VEC[i][15:8];
            @(negedge clk);
            push_b = 1'b0; push_a = 1'b0;
        end
        wait_steps();
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] av;
            av = loop ? ((i == 0) ? TOKEN : VEC[i-1][7:0]) : VEC[i][15:8];
            chk(loop ? "R9 loop c sequence" : {"R1 c value ", tag}, c_log[i], ref_f(av, VEC[i][7:0]));
            chk({"R2 d value ", tag}, d_log[i], VEC[i][7:0]);
        end
        chk({"R8 c count ", tag}, c_cnt, N);
        chk({"R8 d count ", tag}, d_cnt, N);
        chk(loop ? "R9 loop progressed" : {"R8 deq count ", tag}, deq_cnt, N);
    endtask

    // Watchdog: a hung run is a failure that still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fifo_mode = 1'b0; loop_mode = 1'b0;
        dr_a_ne = 0; dr_b_ne = 0; dr_c_nf = 0; dr_d_nf = 0;
        dr_a_first = '0; dr_b_first = '0;
        push_a = 0; push_b = 0; push_a_data = '0; push_b_data = '0;
        cap_a = 3'd2; cap_b = 3'd2; cap_c = 3'd2; cap_d = 3'd2;
        c_div = 1; d_div = 1;

        // Table walk, free drain, then heavy backpressure (R1, R2, R8).
        run_table(1'b0, "free");
        cap_c = 3'd1; cap_d = 3'd1; c_div = 2; d_div = 3;
        run_table(1'b0, "backpressure");

        // Feedback loop d->a through a depth-1 queue with one token (R9).
        cap_a = 3'd1; cap_d = 3'd1; cap_c = 3'd1; c_div = 1; d_div = 1;
        run_table(1'b1, "loop");

        // Directed cycles with direct drive.
        fifo_mode = 1'b0; loop_mode = 1'b0;
        dr_a_ne = 0; dr_b_ne = 0; dr_c_nf = 0; dr_d_nf = 0;
        do_reset();
        #1;
        chk("R7 idle c_enq", c_enq, 0);
        chk("R7 idle d_enq", d_enq, 0);
        chk("R7 idle deq", a_deq, 0);

        dr_b_ne = 1; dr_b_first = 8'h5A; dr_c_nf = 1; dr_d_nf = 1;
        #1;
        chk("R4 d fires without a", d_enq, 1);
        chk("R2 d data", d_data, 8'h5A);
        chk("R3 c waits for a", c_enq, 0);
        chk("R6 no early pop", a_deq, 0);

        @(negedge clk); #1;
        chk("R5 d not repeated", d_enq, 0);
        chk("R6 no pop with one result", a_deq, 0);

        dr_a_ne = 1; dr_a_first = 8'h21; dr_c_nf = 0;
        #1;
        chk("R3 c blocked by full", c_enq, 0);
        @(negedge clk); #1;
        chk("R3 c still blocked", c_enq, 0);
        chk("R5 d still quiet", d_enq, 0);

        dr_c_nf = 1;
        #1;
        chk("R3 c fires", c_enq, 1);
        chk("R1 c data", c_data, 8'h7B);
        chk("R6 pop not with last result", a_deq, 0);

        @(negedge clk); #1;
        chk("R6 finish a_deq", a_deq, 1);
        chk("R6 finish b_deq", b_deq, 1);
        chk("R6 finish quiet c", c_enq, 0);
        chk("R6 finish quiet d", d_enq, 0);

        dr_a_first = 8'hF0; dr_b_first = 8'h20;
        @(negedge clk); #1;
        chk("R6 pop lasts one cycle", a_deq, 0);
        chk("R10 c same cycle", c_enq, 1);
        chk("R10 d same cycle", d_enq, 1);
        chk("R1 c wrap data", c_data, 8'h10);

        @(negedge clk); #1;
        chk("R6 second finish", b_deq, 1);

        @(negedge clk); #1;
        chk("R10 third step fires", d_enq, 1);
        // Reset while both flags are set mid-step.
        @(negedge clk);
        chk("R5 done before reset", d_enq, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R7 d flag cleared", d_enq, 1);
        chk("R7 c flag cleared", c_enq, 1);
        chk("R7 no pop after reset", a_deq, 0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule